// File: doc/BRIEF.md
# Interleaved Serial Codec Word Sequencer

This block stands between a serial PCM/ADPCM bit stream and a codec core that works on one word at a time. Serial bits arrive at half the clock rate, most significant bit first. Every eight bits form a word, and the block presents that word on a parallel port for one cycle, tagged with a channel number and a direction (encode or decode). The codec core returns its result in that same cycle. The block sends that result back out serially during the following slot. A channel marked transparent skips the core: its input word goes back out unchanged.

A three-bit schedule code selects one of three schedules. In the interleaved schedule, the direction alternates word by word, so the stream carries PCM and ADPCM words in turn. The encode-only and decode-only schedules use every slot for one direction. A frame sync pulse aligns the slot count, which wraps after a parameterised number of slots per frame. That number is 48 words by default; 64 suits a faster clock. Encoder results carry a code narrower than the word, and the unused low bits are sent as zeros.

Top module: `cws_top`

## Requirements
- R1: Schedule code 3'b100 selects interleaved, 3'b101 encode-only and 3'b110 decode-only. Any other code is idle: `word_vld_o` stays low, and from the cycle after the code is seen `sout_o` is 0.
- R2: A high `fsync_i` at a rising edge samples `sin_i` as bit 7 of slot 0. Later bits are sampled every second edge, MSB first. The word is presented on `word_o` with `word_vld_o` high for exactly one cycle, the cycle right after the edge that sampled its eighth bit.
- R3: The slot index is 0 for the word that starts at a frame sync. It rises by one per word and wraps to 0 after slot SLOTS-1. A frame sync in the middle of a frame restarts it at 0.
- R4: In interleaved schedule, even slots are encode (`word_dec_o`=0) and odd slots are decode (`word_dec_o`=1), with `word_chan_o` = slot/2.
- R5: In the single-direction schedules, `word_chan_o` equals the slot index. `word_dec_o` is 0 for encode-only and 1 for decode-only.
- R6: `result_i` is taken in the cycle `word_vld_o` is high. It is shifted out on `sout_o` during the next slot, MSB first, and each bit is held for two cycles. Bit 7 appears in the cycle after the edge that samples bit 7 of the next slot.
- R7: When bit `word_chan_o` of `transp_mask_i` is 1, `result_i` is ignored and the 8-bit input word is sent back on `sout_o` unchanged.
- R8: For an encode word that is not transparent, only the top CODE_W bits of the result are sent and the lower 8-CODE_W bits are 0. Decode results are sent with all 8 bits.
- R9: Until the first result has been taken after reset, `sout_o` sends all-zero words.
- R10: While `rst_n` is low, `word_vld_o`, `sout_o` and `word_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; serial bits move at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Schedule code |
| fsync_i | input | 1 | Frame sync, marks bit 7 of slot 0 |
| sin_i | input | 1 | Serial input word stream |
| transp_mask_i | input | SLOTS | Per-channel transparent flags, indexed by channel |
| result_i | input | 8 | Core result for the word being presented |
| sout_o | output | 1 | Serial output word stream |
| word_o | output | 8 | Deserialised input word |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |
| word_chan_o | output | $clog2(SLOTS) | Channel number of the presented word |
| word_dec_o | output | 1 | 1 for a decode word, 0 for an encode word |

## Verification
The bench sends a long stream through more than one frame, so the slot count wraps. A design that failed to wrap, or wrapped one slot late, would report channel numbers past the frame size. One run puts a frame sync at an odd word in the middle of a frame. A counter that ignored it would leave the direction parity off by one from then on. Transparent channels include the first and the last one, so an off-by-one index into the mask would send core results where input words are due. Both out-of-range schedule codes are driven against a live stream, and a design that decoded them loosely would raise word strobes or leave bits on the serial output.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    SCHED_INTL = 3'b100,
    SCHED_ENC  = 3'b101,
    SCHED_DEC  = 3'b110
  } sched_e;

  function automatic logic sched_ok(logic [2:0] m);
    return (m == SCHED_INTL) || (m == SCHED_ENC) || (m == SCHED_DEC);
  endfunction

  // channel number carried by a slot under a given schedule
  function automatic int chan_of(logic [2:0] m, int slot);
    return (m == SCHED_INTL) ? (slot >> 1) : slot;
  endfunction

  // 1 = decode, 0 = encode
  function automatic logic dir_of(logic [2:0] m, int slot);
    if (m == SCHED_DEC) return 1'b1;
    if (m == SCHED_INTL) return slot[0];
    return 1'b0;
  endfunction

  // encoder codes keep only the top code_w bits
  function automatic logic [WORD_W-1:0] shape_word(logic [WORD_W-1:0] res,
                                                   logic dec, int code_w);
    logic [WORD_W-1:0] keep;
    keep = ~({WORD_W{1'b1}} >> code_w);
    return dec ? res : (res & keep);
  endfunction
endpackage

// File: rtl/cws_bit_timer.sv
module cws_bit_timer #(
  parameter int SLOTS = 48,
  localparam int SL_W = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync_i,
  output logic            tick_o,
  output logic            word_begin_o,
  output logic            word_end_o,
  output logic [SL_W-1:0] slot_o
);
  logic       synced_q, ph_q;
  logic [2:0] bc_q;

  assign tick_o       = fsync_i | (synced_q & ph_q);
  assign word_begin_o = tick_o & (fsync_i | (bc_q == 3'd0));
  assign word_end_o   = tick_o & ~fsync_i & (bc_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      ph_q     <= 1'b0;
      bc_q     <= 3'd0;
      slot_o   <= '0;
    end else if (fsync_i) begin
      synced_q <= 1'b1;
      ph_q     <= 1'b0;
      bc_q     <= 3'd1;
      slot_o   <= '0;
    end else if (tick_o) begin
      ph_q <= 1'b0;
      bc_q <= bc_q + 3'd1;
      if (bc_q == 3'd7)
        slot_o <= (slot_o == SL_W'(SLOTS - 1)) ? '0 : slot_o + SL_W'(1);
    end else begin
      ph_q <= synced_q;
    end
  end
endmodule

// File: rtl/cws_deser.sv
module cws_deser
  import cws_pkg::*;
#(
  parameter int SLOTS = 48,
  localparam int SL_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              sin_i,
  input  logic              tick_i,
  input  logic              word_end_i,
  input  logic [SL_W-1:0]   slot_i,
  input  logic [SLOTS-1:0]  transp_mask_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic [SL_W-1:0]   word_chan_o,
  output logic              word_dec_o,
  output logic              word_xp_o
);
  logic [WORD_W-2:0] sh_q;
  logic [SL_W-1:0]   chan_w;

  assign chan_w = SL_W'(chan_of(mode_i, int'(slot_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      word_chan_o <= '0;
      word_dec_o  <= 1'b0;
      word_xp_o   <= 1'b0;
    end else begin
      if (tick_i) sh_q <= {sh_q[WORD_W-3:0], sin_i};
      word_vld_o <= word_end_i & sched_ok(mode_i);
      if (word_end_i && sched_ok(mode_i)) begin
        word_o      <= {sh_q, sin_i};
        word_chan_o <= chan_w;
        word_dec_o  <= dir_of(mode_i, int'(slot_i));
        word_xp_o   <= transp_mask_i[chan_w];
      end
    end
  end
endmodule

// File: rtl/cws_ser.sv
module cws_ser
  import cws_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              word_begin_i,
  input  logic              word_vld_i,
  input  logic              word_dec_i,
  input  logic              word_xp_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] result_i,
  output logic [WORD_W-1:0] pend_o,
  output logic              sout_o
);
  logic [WORD_W-1:0] osh_q;

  assign sout_o = osh_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      osh_q  <= '0;
    end else begin
      if (word_vld_i)
        pend_o <= word_xp_i ? word_i : shape_word(result_i, word_dec_i, CODE_W);
      if (!run_i)            osh_q <= '0;
      else if (word_begin_i) osh_q <= pend_o;
      else if (tick_i)       osh_q <= {osh_q[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/cws_top.sv
module cws_top
  import cws_pkg::*;
#(
  parameter int SLOTS  = 48,
  parameter int CODE_W = 4,
  localparam int CH_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              fsync_i,
  input  logic              sin_i,
  input  logic [SLOTS-1:0]  transp_mask_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              sout_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic [CH_W-1:0]   word_chan_o,
  output logic              word_dec_o
);
  logic            tick_w, begin_w, end_w, run_w, word_xp_w;
  logic [CH_W-1:0] slot_w;
  logic [WORD_W-1:0] pend_w;

  assign run_w = sched_ok(mode_i);

  cws_bit_timer #(.SLOTS(SLOTS)) timer_i (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .tick_o(tick_w),
    .word_begin_o(begin_w), .word_end_o(end_w), .slot_o(slot_w));

  cws_deser #(.SLOTS(SLOTS)) deser_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sin_i(sin_i),
    .tick_i(tick_w), .word_end_i(end_w), .slot_i(slot_w),
    .transp_mask_i(transp_mask_i), .word_o(word_o), .word_vld_o(word_vld_o),
    .word_chan_o(word_chan_o), .word_dec_o(word_dec_o), .word_xp_o(word_xp_w));

  cws_ser #(.CODE_W(CODE_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .tick_i(tick_w),
    .word_begin_i(begin_w), .word_vld_i(word_vld_o), .word_dec_i(word_dec_o),
    .word_xp_i(word_xp_w), .word_i(word_o), .result_i(result_i),
    .pend_o(pend_w), .sout_o(sout_o));
endmodule

// File: rtl/cws_checker.sv
module cws_checker
  import cws_pkg::*;
#(
  parameter int SLOTS  = 48,
  parameter int CODE_W = 4,
  localparam int CH_W  = $clog2(SLOTS),
  localparam int LO_W  = WORD_W - CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              tick,
  input logic              word_vld,
  input logic              word_dec,
  input logic              word_xp,
  input logic [CH_W-1:0]   word_chan,
  input logic [WORD_W-1:0] word,
  input logic [WORD_W-1:0] pend,
  input logic              sout
);
  logic run;
  assign run = sched_ok(mode);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!word_vld && !sout));

  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (int'(word_chan) < SLOTS));

  p_intl_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && $past(mode) == SCHED_INTL) |-> (int'(word_chan) < SLOTS / 2));

  p_enc_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && $past(mode) == SCHED_ENC) |-> !word_dec);

  p_dec_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && $past(mode) == SCHED_DEC) |-> word_dec);

  p_sout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && $past(run)) |-> $stable(sout));

  p_transp_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && word_xp) |=> (pend == $past(word)));

  p_enc_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_dec && !word_xp) |=> (pend[LO_W-1:0] == '0));
endmodule

bind cws_top cws_checker #(.SLOTS(SLOTS), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode_i), .tick(tick_w),
  .word_vld(word_vld_o), .word_dec(word_dec_o), .word_xp(word_xp_w),
  .word_chan(word_chan_o), .word(word_o), .pend(pend_w), .sout(sout_o));

// File: tb/cws_top_tb_top.sv
module cws_top_tb_top;
  localparam int SLOTS  = 48;
  localparam int CODE_W = 4;
  localparam int CH_W   = $clog2(SLOTS);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             fsync = 1'b0, sin = 1'b0;
  logic [2:0]       mode_v = 3'b000;
  logic [SLOTS-1:0] mask_v = '0;
  logic [7:0]       result, word;
  logic             sout, vld, dec;
  logic [CH_W-1:0]  chan;

  // stand-in codec core: answers in the same cycle
  assign result = dec ? ~word : (word ^ 8'h5A);

  cws_top #(.SLOTS(SLOTS), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_v), .fsync_i(fsync), .sin_i(sin),
    .transp_mask_i(mask_v), .result_i(result), .sout_o(sout), .word_o(word),
    .word_vld_o(vld), .word_chan_o(chan), .word_dec_o(dec));

  int cyc = 0, c0 = 0, wsync = 0, n_chk = 0, n_fail = 0;
  bit active = 0, rst_req = 1;

  function automatic logic [7:0] gen(int w);
    return 8'((w * 73 + 29) ^ (w >> 2));
  endfunction
  function automatic bit good_mode();
    return mode_v == 3'b100 || mode_v == 3'b101 || mode_v == 3'b110;
  endfunction
  function automatic int base_of(int w);
    return (wsync > 0 && w >= wsync) ? wsync : 0;
  endfunction
  function automatic int slot_of(int w);
    return (w - base_of(w)) % SLOTS;
  endfunction
  function automatic int ch_of(int w);
    return (mode_v == 3'b100) ? slot_of(w) / 2 : slot_of(w);
  endfunction
  function automatic bit dir_exp(int w);
    if (mode_v == 3'b110) return 1;
    if (mode_v == 3'b100) return (slot_of(w) % 2) == 1;
    return 0;
  endfunction
  function automatic logic [7:0] out_exp(int w);
    if (mask_v[ch_of(w)]) return gen(w);
    if (dir_exp(w)) return ~gen(w);
    return (gen(w) ^ 8'h5A) & (8'hFF << (8 - CODE_W));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(vld == 1'b0, "R10 word_vld in reset", int'(vld), 0);
      chk(sout == 1'b0, "R10 sout in reset", int'(sout), 0);
      chk(word == 8'h00, "R10 word_o in reset", int'(word), 0);
    end else if (active && cyc >= c0) begin
      int m;
      m = cyc - c0;
      if (!good_mode()) begin
        chk(vld == 1'b0, "R1 idle word_vld", int'(vld), 0);
        chk(sout == 1'b0, "R1 idle sout", int'(sout), 0);
      end else begin
        bit ev;
        ev = (m >= 15) && ((m - 15) % 16 == 0);
        chk(vld == ev, "R2 word_vld timing", int'(vld), int'(ev));
        if (ev) begin
          int w;
          w = (m - 15) / 16;
          chk(word == gen(w), "R2 word_o content", int'(word), int'(gen(w)));
          if (mode_v == 3'b100) begin
            chk(int'(chan) == ch_of(w), "R4 interleaved channel", int'(chan), ch_of(w));
            chk(dec == dir_exp(w), "R4 interleaved direction", int'(dec), int'(dir_exp(w)));
          end else begin
            chk(int'(chan) == ch_of(w), "R5 single channel", int'(chan), ch_of(w));
            chk(dec == dir_exp(w), "R5 single direction", int'(dec), int'(dir_exp(w)));
          end
          if (w - base_of(w) == SLOTS)
            chk(int'(chan) == 0, "R3 slot wrap", int'(chan), 0);
          if (wsync > 0 && w == wsync)
            chk(int'(chan) == 0 && dec == dir_exp(w), "R3 mid-frame resync",
                int'(chan), 0);
        end
        if (m <= 16) begin
          chk(sout == 1'b0, "R9 zero before first result", int'(sout), 0);
        end else begin
          int wr, k;
          logic eb;
          string tag;
          wr = (m - 1) / 16 - 1;
          k  = ((m - 1) % 16) / 2;
          eb = out_exp(wr)[7 - k];
          tag = mask_v[ch_of(wr)] ? "R7 transparent sout" :
                (dir_exp(wr) ? "R6 decode sout" : "R8 encode sout");
          chk(sout == eb, tag, int'(sout), int'(eb));
        end
      end
    end
    rst_n = !rst_req;
    if (active && cyc >= c0) begin
      int m, i;
      m = cyc - c0;
      i = m / 2;
      sin   = gen(i / 8)[7 - (i % 8)];
      fsync = (m == 0) || (wsync > 0 && m == 16 * wsync);
    end else begin
      sin   = 1'b0;
      fsync = 1'b0;
    end
  end

  task automatic run(logic [2:0] md, logic [SLOTS-1:0] mk, int ws, int ncyc);
    @(posedge clk);
    active  = 0;
    rst_req = 1;
    mode_v  = md;
    mask_v  = mk;
    wsync   = ws;
    repeat (3) @(posedge clk);
    rst_req = 0;
    repeat (3) @(posedge clk);
    c0     = cyc + 1;
    active = 1;
    repeat (ncyc) @(posedge clk);
    active = 0;
  endtask

  initial begin
    fork
      begin
        run(3'b100, 48'h0000_0080_0021, 0, 16 * 110);
        run(3'b100, 48'h0000_0000_0000, 7, 16 * 70);
        run(3'b101, 48'h8000_0000_0008, 0, 16 * 110);
        run(3'b110, 48'h0000_4000_0001, 0, 16 * 60);
        run(3'b000, 48'h0000_0000_0000, 0, 400);
        run(3'b111, 48'hFFFF_FFFF_FFFF, 0, 400);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule